// File: doc/BRIEF.md
# Registered Eight-Bit Arithmetic Unit with Shared Operand Port

This block puts a register stage around a combinational arithmetic and logic unit. Both operands come in over one byte-wide input, one at a time. A load strobe, qualified by a select bit, writes the byte into operand register A or operand register B. A separate execute strobe captures the unit's full result into two byte registers, low (X) and high (Y), and captures seven status flags on the same edge. The captured result then stays put until the next execute strobe.

One byte-wide output shows either the low or the high result byte, picked by a plain select input. The flags are always visible. The carry input goes straight to the unit and is used by the operations that take a carry. Every control pin is a plain level or a one-cycle strobe. Operand entry has no back-pressure and no handshake: each strobe acts on the edge where it is sampled.

Top module: `seqalu`

## Requirements
- R1: While `rst_i` is high at a rising edge, operand registers A and B, result registers X and Y, and all seven flags are cleared to 0.
- R2: When `ld_i`=1 and `ld_b_i`=0 at a rising edge, A takes `opnd_i`. When `ld_i`=0, neither operand changes.
- R3: When `ld_i`=1 and `ld_b_i`=1 at a rising edge, B takes `opnd_i` and A is left unchanged.
- R4: When `go_i`=1 at a rising edge, X, Y and the flags take the unit's current result. Without `go_i` they hold, even when the operands, `op_i` or `cin_i` change.
- R5: `res_o` shows X when `hi_sel_i`=0 and Y when `hi_sel_i`=1, within the same cycle.
- R6: When `ld_i` and `go_i` are high on the same edge, both actions take place, and the result is computed from the operand values held before that edge.
- R7: The logic operations are code 0 (X=A AND B), code 1 (X=A OR B) and code 2 (X=A XNOR B). Each clears the carry flag and the overflow flag.
- R8: Code 3 computes {carry,X}=A+B unsigned. Code 4 computes X=A+B, sets the overflow flag on two's-complement overflow, and sets the negative flag to X[7]. Code 5 computes {carry,X}=A+B+`cin_i`.
- R9: Code 6 is the signed product {Y,X}=A*B, with the negative flag set to Y[7]. Code 7 computes X=A-B, with the carry flag set when A<B unsigned (a borrow).
- R10: The single-step moves are code 8 (rotate A left by 1), code 9 ({carry,X}={A[7],A[6:0],`cin_i`}), code 10 (logical right shift), code 11 (arithmetic right shift, negative flag = X[7]) and code 12 (left shift, carry = A[7]).
- R11: Code 13 reads {B,A} as four decimal digits, with B[7:4] the most significant, and writes their binary value into {Y,X}. A nibble above 9 keeps its weight.
- R12: Code 14 rotates A left by B[2:0] positions. Code 15 shifts A right logically by B[2:0] positions.
- R13: The flags are as follows. The zero flag is set when {Y,X}=0. The any-flag is the OR of the zero, carry and overflow flags. The palindrome flag is set when X equals X with its bits reversed. The prime flag is set when X, read unsigned, is prime. Y is 0 for every code except 6 and 13. The carry, overflow and negative flags are 0 wherever R7 to R12 do not define them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| opnd_i | input | 8 | Shared operand byte |
| ld_i | input | 1 | Operand load strobe |
| ld_b_i | input | 1 | Load target: 0 = A, 1 = B |
| op_i | input | 4 | Operation code |
| cin_i | input | 1 | Carry input to the unit |
| go_i | input | 1 | Execute strobe, captures result and flags |
| hi_sel_i | input | 1 | Output byte select: 0 = X, 1 = Y |
| res_o | output | 8 | Selected result byte |
| zf_o | output | 1 | Zero flag |
| cf_o | output | 1 | Carry / borrow flag |
| vf_o | output | 1 | Overflow flag |
| any_o | output | 1 | OR of zero, carry and overflow |
| pal_o | output | 1 | Bit-palindrome flag of X |
| prime_o | output | 1 | X is prime |
| neg_o | output | 1 | Result is negative |

## Verification
The hardest case to reach from the ports is the edge where a load and an execute land together. The result must come from the operand that existed before that edge, even though the new operand is already on the bus. The bench first loads a known A and B. It then raises `go_i` together with a load of a very different A, predicts the result from the old A, and runs a second execute to show that the new A was in fact stored. Result holding is reached in a similar way: operands and code are changed with no execute, and the outputs are read again in both byte positions.

// File: rtl/seqalu_pkg.sv
package seqalu_pkg;

  localparam int DATA_W = 8;
  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    OP_AND   = 4'd0,
    OP_OR    = 4'd1,
    OP_XNOR  = 4'd2,
    OP_ADDU  = 4'd3,
    OP_ADDS  = 4'd4,
    OP_ADDC  = 4'd5,
    OP_MULS  = 4'd6,
    OP_SUBU  = 4'd7,
    OP_ROL1  = 4'd8,
    OP_RCL1  = 4'd9,
    OP_SHR1  = 4'd10,
    OP_SAR1  = 4'd11,
    OP_SHL1  = 4'd12,
    OP_DEC2B = 4'd13,
    OP_ROLV  = 4'd14,
    OP_SHRV  = 4'd15
  } op_e;

  typedef struct packed {
    logic zf;
    logic cf;
    logic vf;
    logic any;
    logic pal;
    logic prime;
    logic neg;
  } flags_t;

endpackage

// File: rtl/seqalu_core.sv
module seqalu_core
  import seqalu_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  op_e           op,
  input  logic          cin,
  output logic [DW-1:0] x,
  output logic [DW-1:0] y,
  output logic          cf,
  output logic          vf,
  output logic          neg
);
  localparam int SHW  = $clog2(DW);
  localparam int NDIG = (2 * DW) / 4;

  logic [DW:0]       sum_ab;
  logic [DW:0]       sum_abc;
  logic [DW:0]       diff_ab;
  logic [2*DW-1:0]   prod;
  logic [2*DW-1:0]   dec_val;
  logic [2*DW-1:0]   rot_pair;
  logic [SHW-1:0]    amt;
  logic [2*DW-1:0]   digits;

  assign sum_ab  = {1'b0, a} + {1'b0, b};
  assign sum_abc = sum_ab + {{DW{1'b0}}, cin};
  assign diff_ab = {1'b0, a} - {1'b0, b};
  assign prod    = $signed({{DW{a[DW-1]}}, a}) * $signed({{DW{b[DW-1]}}, b});
  assign amt     = b[SHW-1:0];
  assign rot_pair = {a, a} << amt;
  assign digits  = {b, a};

  // decimal digit string to binary, most significant nibble first
  always_comb begin
    dec_val = '0;
    for (int k = NDIG - 1; k >= 0; k--) begin
      dec_val = dec_val * (2 * DW)'(10) + (2 * DW)'(digits[k*4 +: 4]);
    end
  end

  always_comb begin
    x   = '0;
    y   = '0;
    cf  = 1'b0;
    vf  = 1'b0;
    neg = 1'b0;
    case (op)
      OP_AND:   x = a & b;
      OP_OR:    x = a | b;
      OP_XNOR:  x = ~(a ^ b);
      OP_ADDU:  {cf, x} = sum_ab;
      OP_ADDS: begin
        x   = sum_ab[DW-1:0];
        vf  = (a[DW-1] == b[DW-1]) && (x[DW-1] != a[DW-1]);
        neg = x[DW-1];
      end
      OP_ADDC:  {cf, x} = sum_abc;
      OP_MULS: begin
        {y, x} = prod;
        neg    = prod[2*DW-1];
      end
      OP_SUBU: begin
        x  = diff_ab[DW-1:0];
        cf = diff_ab[DW];
      end
      OP_ROL1:  x = {a[DW-2:0], a[DW-1]};
      OP_RCL1: begin
        x  = {a[DW-2:0], cin};
        cf = a[DW-1];
      end
      OP_SHR1:  x = {1'b0, a[DW-1:1]};
      OP_SAR1: begin
        x   = {a[DW-1], a[DW-1:1]};
        neg = x[DW-1];
      end
      OP_SHL1: begin
        x  = {a[DW-2:0], 1'b0};
        cf = a[DW-1];
      end
      OP_DEC2B: {y, x} = dec_val;
      OP_ROLV:  x = rot_pair[2*DW-1:DW];
      OP_SHRV:  x = a >> amt;
      default:  x = '0;
    endcase
  end

endmodule

// File: rtl/seqalu_flags.sv
module seqalu_flags
  import seqalu_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  logic          cf,
  input  logic          vf,
  input  logic          neg,
  output flags_t        flags
);
  localparam int DIV_LIM = 2 ** ((DW + 1) / 2);

  logic [DW-1:0] x_rev;
  logic          zf;
  logic          prime;

  generate
    for (genvar i = 0; i < DW; i++) begin : g_rev
      assign x_rev[i] = x[DW-1-i];
    end
  endgenerate

  assign zf = ({y, x} == '0);

  // trial division up to the square-root bound of the width
  always_comb begin
    prime = (x >= DW'(2));
    for (int d = 2; d < DIV_LIM; d++) begin
      if ((int'(x) != d) && ((int'(x) % d) == 0)) prime = 1'b0;
    end
  end

  always_comb begin
    flags.zf    = zf;
    flags.cf    = cf;
    flags.vf    = vf;
    flags.any   = zf | cf | vf;
    flags.pal   = (x == x_rev);
    flags.prime = prime;
    flags.neg   = neg;
  end

endmodule

// File: rtl/seqalu.sv
module seqalu
  import seqalu_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int OW = CODE_W
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [DW-1:0] opnd_i,
  input  logic          ld_i,
  input  logic          ld_b_i,
  input  logic [OW-1:0] op_i,
  input  logic          cin_i,
  input  logic          go_i,
  input  logic          hi_sel_i,
  output logic [DW-1:0] res_o,
  output logic          zf_o,
  output logic          cf_o,
  output logic          vf_o,
  output logic          any_o,
  output logic          pal_o,
  output logic          prime_o,
  output logic          neg_o
);
  localparam int NOPND = 2;

  logic [DW-1:0] opnd_q [NOPND];
  logic [DW-1:0] opnd_a;
  logic [DW-1:0] opnd_b;
  logic [DW-1:0] core_x;
  logic [DW-1:0] core_y;
  logic          core_cf;
  logic          core_vf;
  logic          core_neg;
  flags_t        core_flags;
  logic [DW-1:0] x_q;
  logic [DW-1:0] y_q;
  flags_t        flg_q;

  // operand slot g is written when the load target selects it
  generate
    for (genvar g = 0; g < NOPND; g++) begin : g_opnd
      always_ff @(posedge clk_i) begin
        if (rst_i) begin
          opnd_q[g] <= '0;
        end else if (ld_i && (ld_b_i == g[0])) begin
          opnd_q[g] <= opnd_i;
        end
      end
    end
  endgenerate

  assign opnd_a = opnd_q[0];
  assign opnd_b = opnd_q[1];

  seqalu_core #(.DW(DW)) core_i (
    .a   (opnd_a),
    .b   (opnd_b),
    .op  (op_e'(op_i)),
    .cin (cin_i),
    .x   (core_x),
    .y   (core_y),
    .cf  (core_cf),
    .vf  (core_vf),
    .neg (core_neg)
  );

  seqalu_flags #(.DW(DW)) flags_i (
    .x     (core_x),
    .y     (core_y),
    .cf    (core_cf),
    .vf    (core_vf),
    .neg   (core_neg),
    .flags (core_flags)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      x_q   <= '0;
      y_q   <= '0;
      flg_q <= '0;
    end else if (go_i) begin
      x_q   <= core_x;
      y_q   <= core_y;
      flg_q <= core_flags;
    end
  end

  assign res_o   = hi_sel_i ? y_q : x_q;
  assign zf_o    = flg_q.zf;
  assign cf_o    = flg_q.cf;
  assign vf_o    = flg_q.vf;
  assign any_o   = flg_q.any;
  assign pal_o   = flg_q.pal;
  assign prime_o = flg_q.prime;
  assign neg_o   = flg_q.neg;

endmodule

// File: rtl/seqalu_chk.sv
module seqalu_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_i,
  input logic [DW-1:0] opnd_i,
  input logic          ld_i,
  input logic          ld_b_i,
  input logic          go_i,
  input logic [DW-1:0] opnd_a,
  input logic [DW-1:0] opnd_b,
  input logic [DW-1:0] core_x,
  input logic [DW-1:0] core_y,
  input logic [DW-1:0] x_q,
  input logic [DW-1:0] y_q,
  input logic          zf_o,
  input logic          cf_o,
  input logic          vf_o,
  input logic          any_o,
  input logic          pal_o,
  input logic          prime_o,
  input logic          neg_o
);

  p_reset_clear_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(rst_i) |-> (x_q == '0) && (y_q == '0) && (opnd_a == '0) && (opnd_b == '0)
                     && !zf_o && !cf_o && !vf_o && !any_o && !pal_o && !prime_o && !neg_o);

  p_load_a_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (ld_i && !ld_b_i) |=> (opnd_a == $past(opnd_i)) && $stable(opnd_b));

  p_load_b_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (ld_i && ld_b_i) |=> (opnd_b == $past(opnd_i)) && $stable(opnd_a));

  p_opnd_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    !ld_i |=> $stable(opnd_a) && $stable(opnd_b));

  p_capture_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    go_i |=> (x_q == $past(core_x)) && (y_q == $past(core_y)));

  p_result_hold_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    !go_i |=> $stable(x_q) && $stable(y_q)
              && $stable({zf_o, cf_o, vf_o, any_o, pal_o, prime_o, neg_o}));

  p_any_flag_r13: assert property (@(posedge clk_i) disable iff (rst_i)
    any_o == (zf_o | cf_o | vf_o));

endmodule

bind seqalu seqalu_chk #(.DW(DW)) chk_i (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .opnd_i  (opnd_i),
  .ld_i    (ld_i),
  .ld_b_i  (ld_b_i),
  .go_i    (go_i),
  .opnd_a  (opnd_a),
  .opnd_b  (opnd_b),
  .core_x  (core_x),
  .core_y  (core_y),
  .x_q     (x_q),
  .y_q     (y_q),
  .zf_o    (zf_o),
  .cf_o    (cf_o),
  .vf_o    (vf_o),
  .any_o   (any_o),
  .pal_o   (pal_o),
  .prime_o (prime_o),
  .neg_o   (neg_o)
);

// File: tb/seqalu_tb_top.sv
module seqalu_tb_top;

  typedef struct packed {
    logic [7:0] x;
    logic [7:0] y;
    logic [6:0] f;  // {zero, carry, overflow, any, pal, prime, neg}
  } exp_t;

  logic       clk_i = 1'b0;
  logic       rst_i = 1'b1;
  logic [7:0] opnd_i = '0;
  logic       ld_i = 1'b0;
  logic       ld_b_i = 1'b0;
  logic [3:0] op_i = '0;
  logic       cin_i = 1'b0;
  logic       go_i = 1'b0;
  logic       hi_sel_i = 1'b0;
  logic [7:0] res_o;
  logic       zf_o, cf_o, vf_o, any_o, pal_o, prime_o, neg_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] ra = '0;
  logic [7:0] rb = '0;
  exp_t  exp_q[$];
  string tag_q[$];

  always #5 clk_i = ~clk_i;

  seqalu dut_i (
    .clk_i(clk_i), .rst_i(rst_i), .opnd_i(opnd_i), .ld_i(ld_i), .ld_b_i(ld_b_i),
    .op_i(op_i), .cin_i(cin_i), .go_i(go_i), .hi_sel_i(hi_sel_i), .res_o(res_o),
    .zf_o(zf_o), .cf_o(cf_o), .vf_o(vf_o), .any_o(any_o), .pal_o(pal_o),
    .prime_o(prime_o), .neg_o(neg_o)
  );

  function automatic logic is_prime(input logic [7:0] v);
    if (v < 2) return 1'b0;
    for (int d = 2; d < int'(v); d++) if ((int'(v) % d) == 0) return 1'b0;
    return 1'b1;
  endfunction

  function automatic exp_t model(input int op, input logic [7:0] a, input logic [7:0] b,
                                 input logic cin);
    logic [7:0] x = '0, y = '0;
    logic c = 0, v = 0, n = 0, z, pal;
    int s;
    logic [15:0] p;
    logic [7:0] r;
    case (op)
      0: x = a & b;
      1: x = a | b;
      2: x = ~(a ^ b);
      3: begin s = int'(a) + int'(b); x = s[7:0]; c = s[8]; end
      4: begin x = a + b; v = (a[7] == b[7]) && (x[7] != a[7]); n = x[7]; end
      5: begin s = int'(a) + int'(b) + int'(cin); x = s[7:0]; c = s[8]; end
      6: begin s = int'($signed(a)) * int'($signed(b)); p = s[15:0];
               x = p[7:0]; y = p[15:8]; n = p[15]; end
      7: begin x = a - b; c = (a < b); end
      8: x = {a[6:0], a[7]};
      9: begin x = {a[6:0], cin}; c = a[7]; end
      10: x = a >> 1;
      11: begin x = {a[7], a[7:1]}; n = x[7]; end
      12: begin x = a << 1; c = a[7]; end
      13: begin s = int'(b[7:4]) * 1000 + int'(b[3:0]) * 100 + int'(a[7:4]) * 10 + int'(a[3:0]);
                x = s[7:0]; y = s[15:8]; end
      14: begin x = a; for (int k = 0; k < int'(b[2:0]); k++) x = {x[6:0], x[7]}; end
      15: x = a >> b[2:0];
      default: x = '0;
    endcase
    z = ({y, x} == 16'h0);
    for (int k = 0; k < 8; k++) r[k] = x[7-k];
    pal = (r == x);
    return '{x: x, y: y, f: {z, c, v, z | c | v, pal, is_prime(x), n}};
  endfunction

  task automatic load(input logic sel, input logic [7:0] val);
    @(negedge clk_i);
    ld_i = 1'b1; ld_b_i = sel; opnd_i = val;
    @(negedge clk_i);
    ld_i = 1'b0;
    if (sel) rb = val; else ra = val;
  endtask

  // execute strobe; expected item goes to the scoreboard after the capture edge
  task automatic run(input int op, input logic cin, input string tag);
    exp_t e;
    e = model(op, ra, rb, cin);
    @(negedge clk_i);
    op_i = 4'(op); cin_i = cin; go_i = 1'b1;
    @(negedge clk_i);
    go_i = 1'b0;
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  task automatic expect_item(input exp_t e, input string tag);
    @(negedge clk_i);
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  task automatic check(input string tag, input string what, input logic [7:0] act,
                       input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // monitor: reads both result bytes through the output select
  initial begin
    exp_t  e;
    string t;
    forever begin
      @(negedge clk_i);
      #2;
      while (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        hi_sel_i = 1'b0;
        #1;
        check(t, "X via R5 select=0", res_o, e.x);
        check(t, "flags", {1'b0, zf_o, cf_o, vf_o, any_o, pal_o, prime_o, neg_o}, {1'b0, e.f});
        hi_sel_i = 1'b1;
        #1;
        check(t, "Y via R5 select=1", res_o, e.y);
        hi_sel_i = 1'b0;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    exp_t saved;
    repeat (3) @(negedge clk_i);
    rst_i = 1'b0;
    // R1: everything cleared
    expect_item('0, "R1");
    run(3, 1'b0, "R1");

    // R2 R3 R7: logic operations
    load(1'b0, 8'hC5); load(1'b1, 8'h3A);
    run(0, 1'b0, "R7"); run(1, 1'b0, "R7"); run(2, 1'b0, "R7");

    // R8: additions
    load(1'b0, 8'hF0); load(1'b1, 8'h20); run(3, 1'b0, "R8");
    load(1'b0, 8'h70); load(1'b1, 8'h20); run(4, 1'b0, "R8");
    load(1'b0, 8'hFF); load(1'b1, 8'h00); run(5, 1'b1, "R8");

    // R9: multiply and subtract
    load(1'b0, 8'hFD); load(1'b1, 8'h07); run(6, 1'b0, "R9");
    load(1'b0, 8'h10); load(1'b1, 8'h20); run(7, 1'b0, "R9");

    // R10: single-step moves
    load(1'b0, 8'h96);
    for (int op = 8; op <= 12; op++) run(op, 1'b1, "R10");

    // R11: decimal digits to binary
    load(1'b0, 8'h34); load(1'b1, 8'h12); run(13, 1'b0, "R11");

    // R12: variable rotate and shift
    load(1'b0, 8'h81); load(1'b1, 8'h03); run(14, 1'b0, "R12");
    load(1'b0, 8'h80); load(1'b1, 8'h0F); run(15, 1'b0, "R12");

    // R13: palindrome and prime flags
    load(1'b0, 8'h81); load(1'b1, 8'h00); run(1, 1'b0, "R13");
    load(1'b0, 8'h83); load(1'b1, 8'h83); run(0, 1'b0, "R13");

    // R4: result holds while operands and code move
    load(1'b0, 8'h0B); load(1'b1, 8'h0D);
    saved = model(6, ra, rb, 1'b0);
    run(6, 1'b0, "R4");
    load(1'b0, 8'h55); load(1'b1, 8'hAA);
    @(negedge clk_i); op_i = 4'd2; cin_i = 1'b1;
    expect_item(saved, "R4");

    // R6: load and execute on one edge use the old operand
    load(1'b0, 8'h11); load(1'b1, 8'h22);
    saved = model(3, ra, rb, 1'b0);
    @(negedge clk_i);
    op_i = 4'd3; cin_i = 1'b0; go_i = 1'b1; ld_i = 1'b1; ld_b_i = 1'b0; opnd_i = 8'hE0;
    @(negedge clk_i);
    go_i = 1'b0; ld_i = 1'b0; ra = 8'hE0;
    exp_q.push_back(saved); tag_q.push_back("R6");
    run(3, 1'b0, "R6");

    // R3: loading B leaves A intact (A*B with A unchanged)
    load(1'b0, 8'h05); load(1'b1, 8'h03); load(1'b1, 8'h09);
    run(6, 1'b0, "R3");
    // R2: loading A leaves B intact
    load(1'b0, 8'h02); run(6, 1'b0, "R2");

    repeat (4) @(negedge clk_i);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule